// File: doc/BRIEF.md
# Triggered Hit Latch with Delay Window

This block captures which of 64 detector channels fired at a chosen moment before a trigger. Every channel input is sampled on each clock edge into a 64-deep history, so the block always holds the most recent 64 samples of every channel. When an enabled trigger arrives, each channel's history is reduced to one hit bit. The bit is the OR of a group of taps. The start of the group is set by a 6-bit delay, and a 6-bit window mask picks which taps in the group take part. The resulting 64-bit hit pattern is stored as two 32-bit words in an event FIFO that holds 16 events.

Software reaches the block through a simple synchronous register bus. Through it, software loads the delay and window, enables or disables triggers, picks how the FIFO fill level is reported, reads that level, and pops event words one at a time. Read data is combinational and is valid during the cycle in which `bus_rd` is high. A pop takes effect at the clock edge that ends that cycle.

Top module: `hit_latch64`

## Requirements
- R1: After reset, triggers are disabled (`trig_en` = 0), `fifo_ovf` = 0, the FIFO is empty, and reads of the control register (0x00C), mode register (0x000) and level register (0x008) return 0.
- R2: Tap t (0 to 63) of a channel holds the input sampled 64-t clock edges before the trigger edge. Delay D is bits [13:8] of the control register. With window bit 0 alone set, the hit bit equals tap D: D=0 picks the oldest sample and D=63 picks the sample taken one edge before the trigger.
- R3: Window bits [5:0] of the control register select taps: bit j adds tap D+j to the OR. A tap index above 63 contributes nothing and does not wrap. A window of 0 gives a hit bit of 0.
- R4: Each event is two words. The first word holds channels 0 to 31, with channel n at bit n. The second word holds channels 32 to 63, with channel n at bit n-32. Reads of 0x100 return the words in this order, oldest event first.
- R5: A write to 0x028 enables triggers and a write to 0x02C disables them; the write data is ignored. `trig_en` is high while triggers are enabled. A trigger pulse while triggers are disabled stores nothing.
- R6: The FIFO holds 16 events (32 words). An enabled trigger that finds fewer than two free words is dropped and sets `fifo_ovf`, which stays set until reset and is also shown at bit 31 of register 0x008. The free-space check uses the fill level before any pop in the same cycle.
- R7: A read of 0x100 while the FIFO is empty returns 0 and leaves the fill level unchanged.
- R8: Bit 0 of the mode register (written at 0x000) selects how the fill level at 0x008 bits [30:0] is reported. Mode 0 gives unread events, counting a half-read event as one. Mode 1 gives unread words.
- R9: A write to 0x00C stores bits [13:8] and [5:0] of the write data, and a read of 0x00C returns them in the same positions, with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_in | input | 64 | Discriminator output per channel |
| trig | input | 1 | Trigger, one event per cycle high |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| trig_en | output | 1 | Triggers are enabled |
| fifo_ovf | output | 1 | Sticky flag: an event was dropped because the FIFO was full |

## Verification
The bench places a single-edge pulse at a measured distance before the trigger and checks the stored bit against the tap arithmetic. An off-by-one in history order or in tap direction moves the hit to a neighbouring distance. A window that reaches past the newest tap is checked against the oldest sample, which catches an index that wraps instead of clipping. The FIFO is filled with exactly 16 events and then triggered once more. A wrong full test would either overwrite stored data or drop the sixteenth event too early. Empty-FIFO reads and a half-read event check that the level does not go below zero and that the event count rounds up.

// File: rtl/hit_latch64.sv
module hit_latch64 #(
  parameter int EVENTS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] hit_in,
  input  logic        trig,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        trig_en,
  output logic        fifo_ovf
);
  localparam int NCH  = 64;
  localparam int TAPS = 64;
  localparam int WPE  = NCH / 32;
  localparam int FW   = EVENTS * WPE;
  localparam int AW   = $clog2(FW);
  localparam int CW   = $clog2(FW + 1);

  localparam logic [11:0] A_MODE = 12'h000;
  localparam logic [11:0] A_LVL  = 12'h008;
  localparam logic [11:0] A_CTRL = 12'h00C;
  localparam logic [11:0] A_EN   = 12'h028;
  localparam logic [11:0] A_DIS  = 12'h02C;
  localparam logic [11:0] A_DATA = 12'h100;

  logic [TAPS-1:0] hist [NCH];
  logic [NCH-1:0]  hit;
  logic [5:0]      dly, win;
  logic            mode;
  logic [31:0]     mem [FW];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   wcnt;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_mode = bus_wr && bus_addr == A_MODE;
  wire wr_en   = bus_wr && bus_addr == A_EN;
  wire wr_dis  = bus_wr && bus_addr == A_DIS;
  wire pop     = bus_rd && bus_addr == A_DATA && wcnt != '0;
  wire room    = wcnt <= CW'(FW - WPE);
  wire push    = trig && trig_en && room;
  wire drop    = trig && trig_en && !room;

  wire [CW:0] ev_cnt = ({1'b0, wcnt} + (CW+1)'(1)) >> 1;
  wire [CW:0] lvl    = mode ? {1'b0, wcnt} : ev_cnt;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic h;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) hist[ch] <= '0;
      else        hist[ch] <= {hit_in[ch], hist[ch][TAPS-1:1]};

    always_comb begin
      logic [6:0] tap;
      h = 1'b0;
      for (int j = 0; j < 6; j++) begin
        tap = {1'b0, dly} + 7'(j);
        if (win[j] && tap < 7'(TAPS)) h = h | hist[ch][tap[5:0]];
      end
    end
    assign hit[ch] = h;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dly <= '0; win <= '0; mode <= 1'b0;
      trig_en <= 1'b0; fifo_ovf <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        dly <= bus_wdata[13:8];
        win <= bus_wdata[5:0];
      end
      if (wr_mode) mode <= bus_wdata[0];
      if (wr_en)        trig_en <= 1'b1;
      else if (wr_dis)  trig_en <= 1'b0;
      if (drop) fifo_ovf <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; wcnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(WPE);
      if (pop)  rp <= rp + AW'(1);
      wcnt <= wcnt + (push ? CW'(WPE) : '0) - (pop ? CW'(1) : '0);
    end

  always_ff @(posedge clk)
    if (push) begin
      mem[wp]          <= hit[31:0];
      mem[wp + AW'(1)] <= hit[63:32];
    end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd)
      case (bus_addr)
        A_MODE: bus_rdata = {31'b0, mode};
        A_LVL:  bus_rdata = {fifo_ovf, 31'(lvl)};
        A_CTRL: bus_rdata = {18'b0, dly, 2'b0, win};
        A_DATA: bus_rdata = (wcnt != '0) ? mem[rp] : '0;
        default: bus_rdata = '0;
      endcase
  end

  assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CW'(FW));
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);
  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && trig_en && wcnt > CW'(FW - WPE)) |=> (fifo_ovf && wcnt <= $past(wcnt)));
  assert_no_store_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en |=> wcnt <= $past(wcnt));
  assert_enable_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EN) |=> trig_en);
  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DATA && wcnt == '0) |-> bus_rdata == '0);
  assert_empty_keeps_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DATA && wcnt == '0 && !trig) |=> wcnt == '0);
endmodule

// File: tb/test_hit_latch64.sv
module test_hit_latch64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] hit_in = '0;
  logic        trig = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        trig_en, fifo_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hit_latch64 i_hit_latch64 (.*);

  // fields: delay[25:20] window[19:14] channel[13:8] edges-before-trigger[7:1] expected[0]
  localparam logic [25:0] VEC [12] = '{
    {6'd63, 6'b000001, 6'd0,  7'd1,  1'b1},
    {6'd63, 6'b000001, 6'd5,  7'd2,  1'b0},
    {6'd11, 6'b000001, 6'd40, 7'd53, 1'b1},
    {6'd11, 6'b000001, 6'd40, 7'd52, 1'b0},
    {6'd11, 6'b001110, 6'd31, 7'd52, 1'b1},
    {6'd11, 6'b001110, 6'd32, 7'd50, 1'b1},
    {6'd11, 6'b001110, 6'd63, 7'd53, 1'b0},
    {6'd11, 6'b001110, 6'd33, 7'd49, 1'b0},
    {6'd0,  6'b000001, 6'd7,  7'd64, 1'b1},
    {6'd60, 6'b111111, 6'd50, 7'd1,  1'b1},
    {6'd62, 6'b111100, 6'd20, 7'd64, 1'b0},
    {6'd0,  6'b000000, 6'd3,  7'd64, 1'b0}
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w0, w1;
    logic [63:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 trig_en", {31'b0, trig_en}, 0);
    check("R1 fifo_ovf", {31'b0, fifo_ovf}, 0);
    rd(12'h008, d); check("R1 level", d, 0);
    rd(12'h00C, d); check("R1 ctrl", d, 0);
    rd(12'h000, d); check("R1 mode", d, 0);

    wr(12'h00C, 32'hFFFF_3F2A);
    rd(12'h00C, d); check("R9 ctrl readback", d, 32'h0000_3F2A);

    rd(12'h100, d); check("R7 empty read data", d, 0);
    rd(12'h008, d); check("R7 empty read level", d, 0);

    hit_in = '1;
    repeat (3) @(negedge clk);
    wr(12'h00C, 32'h0000_3F01);
    pulse_trig();
    rd(12'h008, d); check("R5 disabled trigger ignored", d, 0);
    check("R5 trig_en low", {31'b0, trig_en}, 0);
    hit_in = '0;

    wr(12'h028, 32'h0);
    check("R5 trig_en high", {31'b0, trig_en}, 1);

    foreach (VEC[i]) begin
      logic [5:0] dv, mv, chv;
      logic [6:0] kv;
      logic [63:0] exp;
      dv = VEC[i][25:20]; mv = VEC[i][19:14]; chv = VEC[i][13:8];
      kv = VEC[i][7:1];
      exp = {63'b0, VEC[i][0]} << chv;
      wr(12'h00C, {18'b0, dv, 2'b0, mv});
      hit_in = '0;
      repeat (70) @(negedge clk);
      hit_in[chv] = 1'b1;
      @(negedge clk);
      hit_in = '0;
      repeat (int'(kv) - 1) @(negedge clk);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      rd(12'h008, d); check("R8 one event", d, 1);
      rd(12'h100, w0);
      rd(12'h100, w1);
      check((chv < 32) ? "R2 R3 low word" : "R3 R4 low word", w0, exp[31:0]);
      check((chv < 32) ? "R2 R3 high word" : "R2 R4 high word", w1, exp[63:32]);
    end
    rd(12'h008, d); check("R7 drained", d, 0);

    pat = 64'hA5C3_0F96_1234_5678;
    hit_in = pat;
    wr(12'h00C, 32'h0000_3F01);
    repeat (2) @(negedge clk);
    for (int n = 0; n < 16; n++) pulse_trig();
    rd(12'h008, d); check("R6 sixteen events", d, 16);
    check("R6 no overflow yet", {31'b0, fifo_ovf}, 0);
    wr(12'h000, 32'h1);
    rd(12'h008, d); check("R8 word level", d, 32);
    pulse_trig();
    rd(12'h008, d); check("R6 drop on full", d, 32'h8000_0020);
    check("R6 fifo_ovf port", {31'b0, fifo_ovf}, 1);
    hit_in = '0;

    rd(12'h100, d); check("R4 first word low", d, pat[31:0]);
    rd(12'h008, d); check("R8 word level after pop", d, 32'h8000_001F);
    wr(12'h000, 32'h0);
    rd(12'h008, d); check("R8 half event counts", d, 32'h8000_0010);
    rd(12'h100, d); check("R4 second word high", d, pat[63:32]);
    for (int n = 0; n < 30; n++) rd(12'h100, d);
    rd(12'h008, d); check("R6 sticky after drain", d, 32'h8000_0000);
    rd(12'h100, d); check("R7 empty after drain", d, 0);

    wr(12'h02C, 32'hFFFF_FFFF);
    check("R5 disable", {31'b0, trig_en}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule